// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits between a two-wire serial memory interface and a 128-word by 8-bit storage array. The bus side opens a write transaction by loading a starting word address. It then hands over data bytes one at a time and finally signals the end of the transaction. The bytes are collected in a four-slot page latch. Only the low two address bits advance from byte to byte, so a fifth byte wraps back and replaces the first. Nothing reaches the array while the transaction is open.

When the transaction ends with at least one byte latched and the write-inhibit pin low, the block starts a self-timed commit. It raises a busy flag for a fixed number of system clocks, which stands in for the programming time of the nonvolatile cell. The bus interface uses that flag to withhold acknowledges. During the first four busy cycles the latched slots are written into the array, which is modelled here as a register file with a combinational read port. While busy is high every bus-side input is ignored. A separate current-address output keeps the address of the last byte written, so a following current-address read can start from the next location.

Top module: `page_commit_buffer`

## Requirements
- R1: After reset, busy and arr_we are low, cur_addr is 0, and every array word reads 0.
- R2: After a load of start address A, the k-th data byte (k counting from 0) is stored at address {A[6:2], (A[1:0]+k) mod 4}. The upper five address bits never change within a transaction.
- R3: When more than four bytes arrive before the end strobe, each later byte replaces the byte held in the same slot, so the array receives only the last byte for each slot.
- R4: The array contents do not change while a transaction is open and before its end strobe.
- R5: An end strobe taken while idle, with wr_ctrl low and at least one byte latched, raises busy on the next cycle. A byte arriving in the same cycle as the end strobe counts as latched. Busy then stays high for exactly WR_CYCLES cycles.
- R6: An end strobe with no byte latched since the last load or end does not raise busy and leaves the array unchanged.
- R7: When wr_ctrl is high at the end strobe, busy stays low, the array is unchanged and the latched bytes are discarded.
- R8: While busy is high, load_addr, byte_valid and stop_strobe have no effect on the array, on cur_addr or on the commit that is under way.
- R9: Only slots written in the transaction are committed. The other words of the same page keep their previous values.
- R10: cur_addr takes the address of each accepted byte in the cycle after it is accepted. A load does not change it.
- R11: arr_we is asserted only while busy is high. Over one commit it pulses exactly once per written slot, with arr_waddr = {page, slot}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_addr | input | 1 | Strobe: start a write transaction at start_addr |
| start_addr | input | 7 | Starting word address |
| byte_valid | input | 1 | Strobe: byte_data holds a received data byte |
| byte_data | input | 8 | Data byte from the bus interface |
| stop_strobe | input | 1 | Strobe: the transaction has ended |
| wr_ctrl | input | 1 | Write inhibit; high vetoes the commit |
| rd_addr | input | 7 | Array read address |
| busy | output | 1 | Commit cycle in progress; bus inputs ignored |
| cur_addr | output | 7 | Address of the last byte written |
| rd_data | output | 8 | Array word at rd_addr (combinational) |
| arr_we | output | 1 | Array write strobe |
| arr_waddr | output | 7 | Array write address |
| arr_wdata | output | 8 | Array write data |

## Verification
Two events can share a cycle: the last data byte and the end strobe. In that case the byte must be folded into the commit rather than lost, and a lone byte arriving with the end strobe must still start a commit. The bench drives byte_valid and stop_strobe together, both after earlier bytes and as the only byte of a transaction. Its behavioural model processes the byte first and then the end. The model is compared on every clock for busy and cur_addr, and a scan of the whole array checks the committed contents.

// File: rtl/page_commit_buffer.sv
module page_commit_buffer #(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 8,
  parameter int PAGE_W    = 2,
  parameter int WR_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_addr,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              stop_strobe,
  input  logic              wr_ctrl,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_waddr,
  output logic [DATA_W-1:0] arr_wdata
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int SLOTS = 1 << PAGE_W;
  localparam int TMR_W = $clog2(WR_CYCLES + 1);

  logic [DATA_W-1:0] mem   [DEPTH];
  logic [DATA_W-1:0] latch [SLOTS];
  logic [SLOTS-1:0]  mask;
  logic [ADDR_W-1:0] ptr;
  logic [TMR_W-1:0]  tmr;

  wire              take_byte = !busy && byte_valid && !load_addr;
  wire [SLOTS-1:0]  slot_hot  = SLOTS'(1) << ptr[PAGE_W-1:0];
  wire [SLOTS-1:0]  mask_nx   = mask | (take_byte ? slot_hot : '0);
  wire              commit    = !busy && stop_strobe && !wr_ctrl && (|mask_nx);
  wire              last      = busy && (tmr == TMR_W'(WR_CYCLES - 1));
  wire [PAGE_W-1:0] slot      = tmr[PAGE_W-1:0];

  assign arr_we    = busy && (tmr < TMR_W'(SLOTS)) && mask[slot];
  assign arr_waddr = {ptr[ADDR_W-1:PAGE_W], slot};
  assign arr_wdata = latch[slot];
  assign rd_data   = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      tmr  <= '0;
      mask <= '0;
      ptr  <= '0;
      cur_addr <= '0;
    end else if (busy) begin
      tmr <= tmr + TMR_W'(1);
      if (last) begin
        busy <= 1'b0;
        mask <= '0;
      end
    end else begin
      if (load_addr) ptr <= start_addr;
      else if (take_byte) begin
        ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + PAGE_W'(1);
        cur_addr <= ptr;
      end
      if (commit) begin
        busy <= 1'b1;
        tmr  <= '0;
        mask <= mask_nx;
      end else if (stop_strobe || load_addr) mask <= '0;
      else mask <= mask_nx;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < SLOTS; i++)
      if (take_byte && ptr[PAGE_W-1:0] == PAGE_W'(i)) latch[i] <= byte_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (arr_we) mem[arr_waddr] <= arr_wdata;
  end

  assert_we_in_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);
  assert_page_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take_byte) |=> ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]));
  assert_busy_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(stop_strobe) && !$past(wr_ctrl)));
  assert_empty_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && stop_strobe && !byte_valid && mask == '0) |=> !busy);
  assert_veto_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && stop_strobe && wr_ctrl) |=> !busy);
  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(ptr) && $stable(cur_addr)));
endmodule

// File: tb/page_commit_buffer_bench.sv
`timescale 1ns/100ps
module page_commit_buffer_bench;
  localparam int WR = 12;
  logic clk = 0, rst_n = 0;
  logic load_addr = 0, byte_valid = 0, stop_strobe = 0, wr_ctrl = 0;
  logic [6:0] start_addr = 0, rd_addr = 0;
  logic [7:0] byte_data = 0;
  logic busy, arr_we;
  logic [6:0] cur_addr, arr_waddr;
  logic [7:0] rd_data, arr_wdata;

  page_commit_buffer #(.WR_CYCLES(WR)) u_page_commit_buffer (
    .clk(clk), .rst_n(rst_n), .load_addr(load_addr), .start_addr(start_addr),
    .byte_valid(byte_valid), .byte_data(byte_data), .stop_strobe(stop_strobe),
    .wr_ctrl(wr_ctrl), .rd_addr(rd_addr), .busy(busy), .cur_addr(cur_addr),
    .rd_data(rd_data), .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  int m_mem [128];
  int m_buf [4];
  bit [3:0] m_mask;
  int m_ptr, m_cur, m_cnt, we_seen, we_exp;
  bit m_busy;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    bit s_rst, s_ld, s_bv, s_st, s_wc, was_busy;
    int s_sa, s_bd;
    s_rst = rst_n; s_ld = load_addr; s_bv = byte_valid; s_st = stop_strobe;
    s_wc = wr_ctrl; s_sa = start_addr; s_bd = byte_data;
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_up();
    end
    #1;
    was_busy = m_busy;
    if (!s_rst) begin
      foreach (m_mem[i]) m_mem[i] = 0;
      m_mask = 0; m_ptr = 0; m_cur = 0; m_busy = 0; m_cnt = 0; we_seen = 0;
    end else if (m_busy) begin
      m_cnt--;
      if (m_cnt == 0) m_busy = 0;
    end else begin
      if (s_ld) begin
        m_ptr = s_sa; m_mask = 0;
      end else if (s_bv) begin
        m_buf[m_ptr % 4] = s_bd;
        m_mask[m_ptr % 4] = 1'b1;
        m_cur = m_ptr;
        m_ptr = (m_ptr & 'h7c) | ((m_ptr + 1) % 4);
      end
      if (s_st) begin
        if (m_mask != 0 && !s_wc) begin
          for (int i = 0; i < 4; i++)
            if (m_mask[i]) m_mem[(m_ptr & 'h7c) | i] = m_buf[i];
          m_busy = 1; m_cnt = WR; we_exp = $countones(m_mask); we_seen = 0;
        end
        m_mask = 0;
      end
    end
    if (s_rst) begin
      chk(busy == m_busy, "R5 R6 R7 busy", busy, m_busy);
      chk(cur_addr == m_cur, "R10 cur_addr", cur_addr, m_cur);
      if (was_busy && !m_busy) chk(we_seen == we_exp, "R11 write pulses", we_seen, we_exp);
      if (m_busy) we_seen += arr_we;
      else begin
        chk(!arr_we, "R11 arr_we while idle", arr_we, 0);
        chk(rd_data == m_mem[rd_addr], "R2 R3 R4 R8 R9 array word", rd_data, m_mem[rd_addr]);
        rd_addr = rd_addr + 1;
      end
    end
  end

  task automatic ld(input int a);
    @(negedge clk); load_addr = 1; start_addr = 7'(a);
    @(negedge clk); load_addr = 0;
  endtask
  task automatic wbyte(input int d);
    @(negedge clk); byte_valid = 1; byte_data = 8'(d);
    @(negedge clk); byte_valid = 0;
  endtask
  task automatic stop(input bit with_byte, input int d);
    @(negedge clk); stop_strobe = 1; byte_valid = with_byte; byte_data = 8'(d);
    @(negedge clk); stop_strobe = 0; byte_valid = 0;
  endtask
  task automatic settle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !arr_we && cur_addr == 0 && rd_data == 0, "R1 reset", {busy, arr_we, cur_addr}, 0);
    rst_n = 1;
    settle(140);
    // R2 R9: full page then partial rewrite
    ld('h24); wbyte('h11); wbyte('h22); wbyte('h33); wbyte('h44); stop(0, 0);
    settle(5);
    // R2: start mid page, wraps from 0x27 to 0x24; 0x25 untouched (R9)
    ld('h26); wbyte('hA6); wbyte('hA7); stop(1, 'hA4);
    settle(5);
    // R3: six bytes overwrite slots 0 and 1
    ld('h40); for (int i = 0; i < 6; i++) wbyte('h50 + i); stop(0, 0);
    settle(5);
    // R6: stop after address only, and a second stop with nothing latched
    ld('h10); stop(0, 0); stop(0, 0);
    settle(5);
    // R7: veto by write-control pin, then empty stop must not commit leftovers
    ld('h60); wbyte('hEE); wbyte('hEF); wr_ctrl = 1; stop(0, 0); wr_ctrl = 0; stop(0, 0);
    settle(5);
    // R5: single byte with stop in the same cycle
    ld('h7F); stop(1, 'h7A);
    // R8: inputs during busy ignored
    ld('h00); wbyte('h99); stop(1, 'h98);
    settle(5);
    // R4: bytes pending, array scanned before stop
    ld('h30); wbyte('hC0); wbyte('hC1);
    repeat (140) @(negedge clk);
    stop(0, 0);
    settle(140);
    finish_up();
  end
endmodule